// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block holds a bank of configuration registers for a display pipeline in two copies. Software writes the shadow copy over a simple write port and reads it back over a combinational read port. The active copy drives the display datapath through a flat output vector. The active copy changes only at a vertical-blanking pulse, so a frame never sees a half-written configuration.

A control register at the address just above the configuration registers selects how copies happen. With automatic loading turned off, software writes the shadow registers and then sets a commit bit. The whole shadow bank moves into the active bank at the next vblank pulse, and the commit bit then clears by itself, so software can poll it to learn that the copy is done. With automatic loading on, every vblank pulse copies the bank. A self-clearing clear bit zeroes the whole shadow bank in one cycle, which gives read-modify-write software known starting values.

Top module: `cfg_shadow_commit`

## Requirements
- R1: A write with `wrValid` high to a configuration address i (0 to NUM_REGS-1) stores `wrData` in shadow register i at that clock edge. A read of address i returns the shadow value, and the active copy does not change.
- R2: The active bank, seen on `activeFlat` with register i at bits [i*DATA_W +: DATA_W], changes only at an edge where a copy takes place and holds its value at every other edge.
- R3: The control register sits at address NUM_REGS. Bit 0 is commit, bit 1 is autoload-disable, bit 2 is clear, and the other bits read as 0. Writing 1 to bit 0 sets the commit bit. The commit bit reads back as 1 until the copy happens, and a later control write with bit 0 at 0 does not cancel it.
- R4: When a vblank pulse is sampled while commit is pending, the full shadow bank is copied into the active bank at that same edge, and the commit bit reads 0 afterwards.
- R5: With autoload-disable at 1 and no commit pending, a vblank pulse leaves the active bank unchanged.
- R6: With autoload-disable at 0, every vblank pulse copies the shadow bank into the active bank, even when no commit is pending.
- R7: A shadow write in the same cycle as a copying vblank lands in the shadow bank. The active bank receives the previous shadow value, and the new value is copied at the next copying vblank.
- R8: Writing 1 to control bit 2 zeroes every shadow register at that edge and leaves the active bank untouched. Bit 2 always reads as 0.
- R9: Reset clears both banks and the commit bit, and sets autoload-disable to 1, so the control register reads 2.
- R10: Reads from addresses above NUM_REGS return 0, and writes to those addresses change no register.
- R11: A commit request written in the same cycle as a vblank pulse, with autoload-disabled and nothing pending, does not copy at that pulse. It stays pending until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write register address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read register address |
| rdData | output | DATA_W | Read data (combinational) |
| vblank | input | 1 | One-cycle vertical-blanking pulse |
| activeFlat | output | NUM_REGS*DATA_W | Active register bank, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench aims at edges where several events meet. In one case a shadow write coincides with a copying vblank: a design that forwarded the write would leak a half-updated frame into the active bank. In another, a commit request coincides with a vblank: a design that looked at the request combinationally would copy one frame too early. The bench also checks that a zero written to the commit bit cannot cancel a pending request, and that vblank without a request leaves the active bank alone when autoload is off. Either fault would make the polling handshake tell software the wrong thing. The clear command must reach every shadow register, and it must not touch the active copy.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  // Bit positions inside the control register word
  localparam int CTRL_COMMIT_BIT = 0;
  localparam int CTRL_AUTODIS_BIT = 1;
  localparam int CTRL_CLEAR_BIT = 2;

  // Strobes from the control side to the bank datapath
  typedef struct packed {
    logic load;   // copy whole shadow bank into active bank
    logic clear;  // zero whole shadow bank
  } bankStrobe_t;

endpackage

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
  import shadow_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CTRL_ADDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              vblank,
  output bankStrobe_t       strobe,
  output logic              commitPend,
  output logic              autoloadDis
);

  logic ctrlWr;
  logic commitReq;

  assign ctrlWr    = wrValid && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign commitReq = ctrlWr && wrData[CTRL_COMMIT_BIT];

  // A copy happens only on a vblank pulse, and only if a request is
  // already pending or autoload is on.
  assign strobe.load  = vblank && (commitPend || !autoloadDis);
  assign strobe.clear = ctrlWr && wrData[CTRL_CLEAR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitPend  <= 1'b0;
      autoloadDis <= 1'b1;
    end else begin
      if (ctrlWr) autoloadDis <= wrData[CTRL_AUTODIS_BIT];
      commitPend <= (commitPend && !strobe.load) || commitReq;
    end
  end

  // R3: a pending commit survives every cycle without vblank
  a_r3_commit_held: assert property (@(posedge clk) disable iff (!rstN)
    commitPend && !vblank |=> commitPend);

  // R4: a vblank consumes the pending commit unless a new one arrives
  a_r4_commit_done: assert property (@(posedge clk) disable iff (!rstN)
    commitPend && vblank && !commitReq |=> !commitPend);

  // R11: a request arriving with the pulse does not take that pulse
  a_r11_no_early_take: assert property (@(posedge clk) disable iff (!rstN)
    vblank && !commitPend && autoloadDis |=> !$past(strobe.load));

endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  bankStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic                       commitPend,
  input  logic                       autoloadDis,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat
);

  localparam int FLAT_W = NUM_REGS * DATA_W;
  localparam int CTRL_ADDR = NUM_REGS;

  logic [DATA_W-1:0] shadowReg [NUM_REGS];
  logic [DATA_W-1:0] activeReg [NUM_REGS];
  logic [FLAT_W-1:0] shadowFlat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wrValid && (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowReg[i] <= '0;
      end else if (strobe.clear) begin
        shadowReg[i] <= '0;
      end else if (hit) begin
        shadowReg[i] <= wrData;
      end
    end

    // The active copy takes the pre-edge shadow value
    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeReg[i] <= '0;
      end else if (strobe.load) begin
        activeReg[i] <= shadowReg[i];
      end
    end

    assign activeFlat[i*DATA_W +: DATA_W] = activeReg[i];
    assign shadowFlat[i*DATA_W +: DATA_W] = shadowReg[i];
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rdAddr == ADDR_W'(k)) rdData = shadowReg[k];
    end
    if (rdAddr == ADDR_W'(CTRL_ADDR)) begin
      rdData[CTRL_COMMIT_BIT]  = commitPend;
      rdData[CTRL_AUTODIS_BIT] = autoloadDis;
    end
  end

  // R2: the active bank holds whenever no copy is requested
  a_r2_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(activeFlat));

  // R4: a copy moves the whole pre-edge shadow bank
  a_r4_bank_copy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> activeFlat == $past(shadowFlat));

  // R8: clear zeroes every shadow register
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> shadowFlat == '0);

endmodule

// File: rtl/cfg_shadow_commit.sv
module cfg_shadow_commit
  import shadow_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  input  logic                       vblank,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat
);

  bankStrobe_t strobe;
  logic        commitPend;
  logic        autoloadDis;

  shadow_commit_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(NUM_REGS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .vblank(vblank), .strobe(strobe),
    .commitPend(commitPend), .autoloadDis(autoloadDis)
  );

  shadow_bank_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .rdAddr(rdAddr),
    .commitPend(commitPend), .autoloadDis(autoloadDis),
    .rdData(rdData), .activeFlat(activeFlat)
  );

endmodule

// File: tb/tb_cfg_shadow_commit.sv
module tb_cfg_shadow_commit;

  localparam int NREG = 8;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] CTRL = 4'd8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic vblank = 1'b0;
  logic [NREG*DW-1:0] activeFlat;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfg_shadow_commit #(.NUM_REGS(NREG), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .vblank(vblank), .activeFlat(activeFlat)
  );

  typedef struct packed {
    logic          wv;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          vb;
    logic [AW-1:0] chk;
    logic [DW-1:0] expSh;
    logic [DW-1:0] expAct;
    logic [7:0]    req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b1, 4'd2, 32'hA5A50002, 1'b0, 4'd2, 32'hA5A50002, 32'h0, 8'd1},        // R1
    '{1'b0, 4'd0, 32'h0,        1'b1, 4'd2, 32'hA5A50002, 32'h0, 8'd5},        // R5
    '{1'b1, 4'd8, 32'h3,        1'b0, 4'd2, 32'hA5A50002, 32'h0, 8'd3},        // R3
    '{1'b0, 4'd0, 32'h0,        1'b1, 4'd2, 32'hA5A50002, 32'hA5A50002, 8'd4}, // R4
    '{1'b1, 4'd5, 32'h11110005, 1'b1, 4'd5, 32'h11110005, 32'h0, 8'd5},        // R5
    '{1'b1, 4'd8, 32'h3,        1'b0, 4'd5, 32'h11110005, 32'h0, 8'd3},        // R3
    '{1'b1, 4'd5, 32'h22220005, 1'b1, 4'd5, 32'h22220005, 32'h11110005, 8'd7}, // R7
    '{1'b1, 4'd8, 32'h3,        1'b0, 4'd5, 32'h22220005, 32'h11110005, 8'd2}, // R2
    '{1'b0, 4'd0, 32'h0,        1'b1, 4'd5, 32'h22220005, 32'h22220005, 8'd7}, // R7
    '{1'b1, 4'd8, 32'h0,        1'b0, 4'd2, 32'hA5A50002, 32'hA5A50002, 8'd2}, // R2
    '{1'b1, 4'd2, 32'h0BAD0002, 1'b1, 4'd2, 32'h0BAD0002, 32'hA5A50002, 8'd7}, // R7
    '{1'b0, 4'd0, 32'h0,        1'b1, 4'd2, 32'h0BAD0002, 32'h0BAD0002, 8'd6}, // R6
    '{1'b1, 4'd7, 32'h00000077, 1'b0, 4'd7, 32'h00000077, 32'h0, 8'd1},        // R1
    '{1'b0, 4'd0, 32'h0,        1'b1, 4'd7, 32'h00000077, 32'h00000077, 8'd6}  // R6
  };

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; inputs change at the falling edge
  task automatic step(input logic wv, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic vb);
    @(negedge clk);
    wrValid = wv; wrAddr = a; wrData = d; vblank = vb;
    @(negedge clk);
    wrValid = 1'b0; vblank = 1'b0;
  endtask

  function automatic logic [DW-1:0] act(input int i);
    return activeFlat[i*DW +: DW];
  endfunction

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [NREG*DW-1:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), v);
      check(v == 0, "R9 shadow", v, 0);
    end
    check(activeFlat == '0, "R9 active", activeFlat[DW-1:0], 0);
    rd(CTRL, v);
    check(v == 32'h2, "R9 ctrl", v, 32'h2);

    // Vector table
    for (int n = 0; n < 14; n++) begin
      step(VECS[n].wv, VECS[n].a, VECS[n].d, VECS[n].vb);
      rd(VECS[n].chk, v);
      check(v == VECS[n].expSh, $sformatf("R%0d shadow vec %0d", VECS[n].req, n),
            v, VECS[n].expSh);
      check(act(int'(VECS[n].chk)) == VECS[n].expAct,
            $sformatf("R%0d active vec %0d", VECS[n].req, n),
            act(int'(VECS[n].chk)), VECS[n].expAct);
    end

    // R11: commit written together with vblank waits one pulse
    step(1'b1, CTRL, 32'h2, 1'b0);
    step(1'b1, 4'd1, 32'h00000111, 1'b0);
    step(1'b1, CTRL, 32'h3, 1'b1);
    check(act(1) == 0, "R11 no copy same pulse", act(1), 0);
    rd(CTRL, v);
    check(v == 32'h3, "R11 commit pending", v, 32'h3);
    // R3: writing 0 to commit does not cancel
    step(1'b1, CTRL, 32'h2, 1'b0);
    rd(CTRL, v);
    check(v == 32'h3, "R3 no cancel", v, 32'h3);
    step(1'b0, 4'd0, 32'h0, 1'b1);
    check(act(1) == 32'h111, "R4 copy after pulse", act(1), 32'h111);
    rd(CTRL, v);
    check(v == 32'h2, "R4 commit cleared", v, 32'h2);

    // R8: clear zeroes shadow only
    step(1'b1, CTRL, 32'h6, 1'b0);
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), v);
      check(v == 0, "R8 shadow cleared", v, 0);
    end
    check(act(2) == 32'h0BAD0002, "R8 active kept", act(2), 32'h0BAD0002);
    rd(CTRL, v);
    check(v == 32'h2, "R8 clear bit reads 0", v, 32'h2);

    // R10: unmapped addresses
    step(1'b1, 4'd12, 32'hFFFFFFFF, 1'b0);
    rd(4'd12, v);
    check(v == 0, "R10 read unmapped", v, 0);
    rd(4'd15, v);
    check(v == 0, "R10 read top", v, 0);
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), v);
      check(v == 0, "R10 write ignored", v, 0);
    end

    // R5/R2: idle vblank with autoload off keeps the active bank
    snap = activeFlat;
    step(1'b0, 4'd0, 32'h0, 1'b1);
    check(activeFlat == snap, "R5 idle vblank", activeFlat[DW-1:0], snap[DW-1:0]);

    // R9: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(activeFlat == '0, "R9 active after reset", activeFlat[DW-1:0], 0);
    rd(CTRL, v);
    check(v == 32'h2, "R9 ctrl after reset", v, 32'h2);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule